// File: doc/BRIEF.md
# Match Timer with Synchronised Clear

A register-mapped up-counter for event timing. Software programs a compare value, a prescale ratio and two control bits over a single-cycle write bus; the counter then advances on a slow timer tick strobe and signals a one-cycle interrupt pulse each time it steps onto the compare value. Optionally the counter returns to zero at that point, which makes it a periodic tick source. The counter wraps through its full width otherwise.

Zeroing the counter from software is not immediate: the request travels through a small synchroniser that advances only on timer ticks. Until the clear lands in the counter, a status bit stays high, so software polls it before it turns the counter on again. A second clear written while one is still in flight merges with it.

All state sits on one bus clock. `tick_en` is the slow timer strobe, one bus cycle wide. Reads are combinational from the address.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and the status bit is clear.
- R2: Control bit 0 (offset 0x08) gates counting; with it clear, ticks leave the count unchanged. With it set, the count (offset 0x04) goes up by one per prescaled tick.
- R3: The 2-bit divider field at offset 0x10, bits 1:0, holding n makes the count advance once every n+1 ticks.
- R4: The count wraps from its all-ones value to zero and keeps counting.
- R5: `irq` is high for exactly one bus cycle, the cycle after a tick on which the count steps onto the compare value (offset 0x00). It never rises while counting is disabled, and it never rises because the compare value is written equal to a count that is not moving.
- R6: With control bit 1 set, the count goes to zero instead of to the compare value on that step. The interrupt still fires.
- R7: Any write to offset 0x0C, whatever the data, zeroes the count and the prescaler on the third tick after the write. A clear written while one is pending merges into the pending one.
- R8: Status bit 10 at offset 0x14 reads 1 from the cycle after a clear write until the tick on which the clear lands, and 0 otherwise.
- R9: Writes to the count offset 0x04 and to the status offset are ignored. Reads of offset 0x0C and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Match interrupt pulse |

## Verification
A wrong prescaler phase or a count that is off by one shows up at the count register on the very next tick, and it moves the interrupt pulse to a different tick within one compare period. A synchroniser stage too many or too few moves the tick on which both the count and the status bit drop by one tick. A broken merge of a repeated clear either releases the status bit early or leaves it stuck high, and a poll of offset 0x14 exposes this within three ticks.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MATCH = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;

    localparam int STAT_PEND_BIT = 10;

    // control bits: [1] zero on match, [0] run
    typedef struct packed {
        logic wrap_on_hit;
        logic run;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_MATCH,
        SEL_COUNT,
        SEL_CTRL,
        SEL_CLEAR,
        SEL_DIV,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MATCH: return SEL_MATCH;
            OFS_COUNT: return SEL_COUNT;
            OFS_CTRL:  return SEL_CTRL;
            OFS_CLEAR: return SEL_CLEAR;
            OFS_DIV:   return SEL_DIV;
            OFS_STAT:  return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                pend,
    output logic [BUS_W-1:0]    rdata,
    output logic [CNT_W-1:0]    match_q,
    output ctrl_t               ctrl_q,
    output logic [DIV_W-1:0]    div_q,
    output logic                clr_wr
);

    reg_sel_e sel;
    logic     unused_wdata_hi;

    assign sel             = decode_ofs(addr);
    assign clr_wr          = wr_en && (sel == SEL_CLEAR);
    assign unused_wdata_hi = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            ctrl_q  <= '0;
            div_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MATCH: match_q <= wdata[CNT_W-1:0];
                SEL_CTRL:  ctrl_q  <= ctrl_t'(wdata[1:0]);
                SEL_DIV:   div_q   <= wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_MATCH: rdata = BUS_W'(match_q);
            SEL_COUNT: rdata = BUS_W'(cnt);
            SEL_CTRL:  rdata = BUS_W'(ctrl_q);
            SEL_DIV:   rdata = BUS_W'(div_q);
            SEL_STAT:  rdata = BUS_W'(pend) << STAT_PEND_BIT;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/timer_clr_sync.sv
module timer_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic clr_wr,
    output logic pend,
    output logic clr_fire
);

    logic              req_q;
    logic              ack_q;
    logic [STAGES-1:0] sync_q;

    assign pend     = req_q ^ ack_q;
    assign clr_fire = tick_en && (sync_q[STAGES-1] != ack_q);

    // request toggles once per clear; a write during a pending clear merges
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else if (clr_wr && !pend)
            req_q <= ~req_q;
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[s] <= 1'b0;
                else if (tick_en)
                    sync_q[s] <= (s == 0) ? req_q : sync_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            ack_q <= 1'b0;
        else if (tick_en)
            ack_q <= sync_q[STAGES-1];
    end

endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  ctrl_t            ctrl,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] match_val,
    input  logic             clr_fire,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] nxt;
    logic             due;
    logic             hit;

    assign nxt = cnt_q + ONE;
    assign due = tick_en && ctrl.run && (pre_q == div);
    assign hit = due && (nxt == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pre_q <= '0;
            irq_q <= 1'b0;
        end else if (clr_fire) begin
            cnt_q <= '0;
            pre_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
            if (tick_en && ctrl.run) begin
                if (due) begin
                    pre_q <= '0;
                    cnt_q <= (hit && ctrl.wrap_on_hit) ? '0 : nxt;
                end else begin
                    pre_q <= pre_q + DIV_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/match_timer.sv
module match_timer
    import timer_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] match_q;
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             clr_wr;
    logic             pend;
    logic             clr_fire;

    timer_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt     (cnt),
        .pend    (pend),
        .rdata   (rdata),
        .match_q (match_q),
        .ctrl_q  (ctrl_q),
        .div_q   (div_q),
        .clr_wr  (clr_wr)
    );

    timer_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .clr_wr   (clr_wr),
        .pend     (pend),
        .clr_fire (clr_fire)
    );

    timer_core #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .ctrl      (ctrl_q),
        .div       (div_q),
        .match_val (match_q),
        .clr_fire  (clr_fire),
        .cnt_q     (cnt),
        .irq_q     (irq)
    );

endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
    import timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic              pend,
    input logic              run,
    input logic              wrap_on_hit,
    input logic [DIV_W-1:0]  div
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));

    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !run && !pend) |=> $stable(cnt));

    assert_plain_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_en && run && !pend && div == '0 && !wrap_on_hit) |=> cnt == $past(cnt) + ONE);

    assert_irq_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(tick_en) && $past(run)));

    assert_pend_set_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CLEAR) |=> pend);

    assert_clear_lands_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> cnt == '0);

    assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_CLEAR || addr > OFS_STAT) |-> rdata == '0);

endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .rdata       (rdata),
    .irq         (irq),
    .cnt         (cnt),
    .pend        (pend),
    .run         (ctrl_q.run),
    .wrap_on_hit (ctrl_q.wrap_on_hit),
    .div         (div_q)
);

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;

    localparam int CW   = 8;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the programmed state
    int m_cnt, m_pre, m_div, m_match, clr_left;
    bit m_run, m_wrap;

    match_timer #(.CNT_W(CW)) i_match_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            8'h00: m_match = int'(d) & MASK;
            8'h08: begin m_run = d[0]; m_wrap = d[1]; end
            8'h0C: if (clr_left == 0) clr_left = 3;
            8'h10: m_div = int'(d[1:0]);
            default: ;
        endcase
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick(input string req);
        bit exp_irq = 0;
        bit fire = 0;
        logic [31:0] d;
        if (clr_left > 0) begin
            clr_left--;
            fire = (clr_left == 0);
        end
        if (fire) begin
            m_cnt = 0; m_pre = 0;
        end else if (m_run) begin
            if (m_pre == m_div) begin
                int nx = (m_cnt + 1) & MASK;
                m_pre = 0;
                exp_irq = (nx == m_match);
                m_cnt = (exp_irq && m_wrap) ? 0 : nx;
            end else begin
                m_pre++;
            end
        end
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        #1;
        check(irq == exp_irq, {req, " irq"}, irq, exp_irq);
        @(negedge clk);
        #1;
        check(irq == 1'b0, "R5 pulse width", irq, 0);
        bus_rd(8'h04, d);
        check(d == m_cnt, {req, " count"}, d, m_cnt);
    endtask

    task automatic settle_clear();
        bus_wr(8'h0C, 32'h0);
        for (int i = 0; i < 3; i++) tick("R7");
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        m_cnt = 0; m_pre = 0; m_div = 0; m_match = 0; clr_left = 0;
        m_run = 0; m_wrap = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state over the whole map
        for (int a = 0; a < 32; a += 4) begin
            bus_rd(8'(a), d);
            check(d == 0, "R1 reset read", d, 0);
        end
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R2 / R3: every divider value, then hold with run off
        for (int dv = 0; dv < 4; dv++) begin
            settle_clear();
            bus_wr(8'h10, 32'(dv));
            bus_rd(8'h10, d);
            check(d == dv, "R3 divider readback", d, dv);
            bus_wr(8'h00, 32'd200);
            bus_wr(8'h08, 32'h1);
            for (int i = 0; i < 13; i++) tick("R3");
            bus_wr(8'h08, 32'h0);
            for (int i = 0; i < 4; i++) tick("R2");
        end

        // R5: compare written equal to a frozen count, and run off
        bus_wr(8'h00, 32'(m_cnt));
        tick("R5");
        bus_wr(8'h00, 32'((m_cnt + 1) & MASK));
        tick("R5");

        // R4 / R5: full wraps with periodic match
        settle_clear();
        bus_wr(8'h10, 32'h0);
        bus_wr(8'h00, 32'd5);
        bus_wr(8'h08, 32'h1);
        for (int i = 0; i < 600; i++) tick("R4");

        // R6: zero on match with divider 1
        settle_clear();
        bus_wr(8'h10, 32'h1);
        bus_wr(8'h00, 32'd10);
        bus_wr(8'h08, 32'h3);
        for (int i = 0; i < 50; i++) tick("R6");

        // R7 / R8: clear with arbitrary data while running
        bus_wr(8'h08, 32'h1);
        bus_wr(8'h10, 32'h0);
        bus_wr(8'h00, 32'd250);
        for (int i = 0; i < 7; i++) tick("R2");
        bus_wr(8'h0C, 32'hDEAD_BEEF);
        for (int i = 0; i < 3; i++) begin
            bus_rd(8'h14, d);
            check(d == (32'h1 << 10), "R8 pending", d, 32'h400);
            tick("R7");
        end
        bus_rd(8'h14, d);
        check(d == 0, "R8 released", d, 0);

        // R7: second clear while pending merges
        for (int i = 0; i < 5; i++) tick("R2");
        bus_wr(8'h0C, 32'h1);
        tick("R7");
        bus_wr(8'h0C, 32'h2);
        tick("R7");
        bus_rd(8'h14, d);
        check(d == 32'h400, "R8 merged pending", d, 32'h400);
        tick("R7");
        bus_rd(8'h14, d);
        check(d == 0, "R8 merged released", d, 0);
        tick("R7");

        // R9: read-only and unmapped offsets
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h04, 32'h55);
        bus_rd(8'h04, d);
        check(d == m_cnt, "R9 count write ignored", d, m_cnt);
        bus_wr(8'h14, 32'hFFFF_FFFF);
        bus_rd(8'h14, d);
        check(d == 0, "R9 status write ignored", d, 0);
        bus_rd(8'h0C, d);
        check(d == 0, "R9 clear reads zero", d, 0);
        bus_rd(8'h18, d);
        check(d == 0, "R9 unmapped", d, 0);
        bus_rd(8'hFC, d);
        check(d == 0, "R9 unmapped high", d, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule